// File: doc/BRIEF.md
# Skid-Buffered Stage Controller

This block is the control and holding logic for one thread of an in-order pipeline stage whose output bandwidth is narrower than its input. Each cycle the upstream stage offers up to `FETCH_W` opaque tagged entries, and the block passes up to `OUT_W` of them downstream. An entry whose squashed bit is set is dropped and takes no output slot. Three downstream sources can each hold the stage back. Each source raises its own stall flag with a set pulse and lowers it with a clear pulse.

Entries the stage cannot pass on are parked in a skid buffer. This happens while a stall is present, or when more survive than the output can take. The upstream stage gets a one-cycle block pulse when the thread enters the blocked state. Once the stall is gone, the skid buffer is emptied oldest first before fresh upstream entries are forwarded again. A one-cycle unblock pulse then announces the return to normal flow. A flush request discards everything held and moves the thread into a squashing state for at least one cycle. A flush-hold input keeps the thread there.

All outputs are registered. Forwarded entries, the pulses and the state appear in the cycle after the inputs that caused them.

Top module: `skid_stage_ctrl`

## Requirements
- R1: After reset, `stateOut` is Idle (0), `blockUp` and `unblockUp` are 0, `outCount` is 0 and `overflowErr` is 0. The state codes are Idle 0, Running 1, Blocked 2, Unblocking 3 and Squashing 4.
- R2: Bit i of `stallSet` sets stall flag i and bit i of `stallClr` clears it; clear wins if both are high. When any flag is set after this update, every entry offered that cycle is appended to the skid buffer and nothing is forwarded.
- R3: `blockUp` pulses for one cycle, and `stateOut` becomes Blocked, when the thread enters Blocked. No pulse is given if the thread was already Blocked.
- R4: In Idle, Running or Squashing, with no stall or flush, entries are taken from slot 0 of the input upward. Squashed entries are dropped without using a slot, and at most `OUT_W` survivors are forwarded, oldest in output slot 0. `outValid` has the low `outCount` bits set.
- R5: If input entries remain after the output slots are full, those remaining entries go to the skid buffer. The thread then blocks as in R3.
- R6: In Blocked or Unblocking with no stall, entries are drained from the skid buffer, oldest first and following R4's slot rules. Entries offered in that cycle are appended behind the skid contents; none are forwarded directly.
- R7: When the skid buffer is empty after such a drain-and-append, `unblockUp` pulses and the thread goes to Running. Otherwise it goes to Unblocking.
- R8: `flushReq` or `flushHold` empties the skid buffer, discards the input, forwards nothing and moves the thread to Squashing. If the thread was Blocked or Unblocking, `unblockUp` pulses.
- R9: A Squashing thread with no flush or stall returns to Running in the same cycle and forwards that cycle's input under R4.
- R10: Each cycle is resolved in this priority: flush, then stall, then leaving Blocked or Unblocking, then normal flow. A stall set together with a flush therefore gives no `blockUp` pulse.
- R11: `overflowErr` goes high and stays high once an append would exceed the skid depth. Entries beyond the depth are discarded.
- R12: The skid depth is `UP_DELAY*FETCH_W + OUT_W` (6 by default). Holding exactly that many entries does not raise `overflowErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inCount | input | $clog2(FETCH_W+1) | Number of entries offered, in slots 0 to inCount-1 |
| inSquashed | input | FETCH_W | Squashed bit for each input slot |
| inTag | input | FETCH_W*TAG_W | Payload for each input slot, slot 0 in the low bits |
| stallSet | input | NUM_SRC | Per-source stall set pulses |
| stallClr | input | NUM_SRC | Per-source stall clear pulses |
| flushReq | input | 1 | Flush request |
| flushHold | input | 1 | Flush-in-progress hold |
| outValid | output | OUT_W | Per-slot valid of forwarded entries |
| outCount | output | $clog2(OUT_W+1) | Number of forwarded entries |
| outTag | output | OUT_W*TAG_W | Forwarded payloads, slot 0 in the low bits |
| blockUp | output | 1 | One-cycle block pulse to upstream |
| unblockUp | output | 1 | One-cycle unblock pulse to upstream |
| stateOut | output | 3 | Current thread state code |
| overflowErr | output | 1 | Sticky skid overflow flag |

## Verification
Directed sequences check specific behaviour:
- An input with a squashed entry in the middle distinguishes slot-skipping from slot-wasting.
- A full-width input with no stall separates the leftover-block path from the stall path.
- Overlapping stalls from two sources, lifted one at a time, show that only the last clear releases the thread and that no second block pulse appears.
- A flush while blocked, a flush hold, and a flush raised together with a stall set pin down the pulse rules and the priority order.
- Filling the skid exactly to its depth and then one entry past it separates R12 from R11.

A long random run with a well-behaved upstream follows. It mixes stalls, flushes, squashed entries and variable input counts, and compares every output every cycle against a behavioural model.

// File: rtl/skid_stage_pkg.sv
package skid_stage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASH     = 3'd4
  } stage_state_e;

  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic clearAll;  // flush: drop skid contents and input
    logic park;      // stall: append every input entry to the skid
    logic fromSkid;  // drain skid head, append input behind it
    logic fromIn;    // forward from input, park any remainder
  } dp_strobe_t;

endpackage

// File: rtl/skid_stage_fsm.sv
module skid_stage_fsm
  import skid_stage_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] stallSet,
  input  logic [NUM_SRC-1:0] stallClr,
  input  logic               flushReq,
  input  logic               flushHold,
  input  logic               leftoverIn,
  input  logic               skidEmptyNext,
  output dp_strobe_t         strobe,
  output logic [2:0]         stateOut,
  output logic               blockUp,
  output logic               unblockUp
);

  stage_state_e       stateQ, stateNext;
  logic [NUM_SRC-1:0] flagsQ, flagsNext;
  logic               stalledNow;
  logic               heldBack;
  logic               blockNext, unblockNext;

  assign flagsNext  = (flagsQ | stallSet) & ~stallClr;
  assign stalledNow = |flagsNext;
  assign heldBack   = (stateQ == ST_BLOCKED) || (stateQ == ST_UNBLOCKING);

  // Strobe selection depends only on state and inputs, not on datapath feedback.
  always_comb begin
    strobe = '0;
    if (flushReq || flushHold)  strobe.clearAll = 1'b1;
    else if (stalledNow)        strobe.park     = 1'b1;
    else if (heldBack)          strobe.fromSkid = 1'b1;
    else                        strobe.fromIn   = 1'b1;
  end

  always_comb begin
    stateNext   = stateQ;
    blockNext   = 1'b0;
    unblockNext = 1'b0;
    if (flushReq || flushHold) begin
      unblockNext = heldBack;
      stateNext   = ST_SQUASH;
    end else if (stalledNow) begin
      if (stateQ != ST_BLOCKED) begin
        blockNext = 1'b1;
        stateNext = ST_BLOCKED;
      end
    end else if (heldBack) begin
      if (skidEmptyNext) begin
        unblockNext = 1'b1;
        stateNext   = ST_RUN;
      end else begin
        stateNext   = ST_UNBLOCKING;
      end
    end else if (leftoverIn) begin
      blockNext = 1'b1;
      stateNext = ST_BLOCKED;
    end else if (stateQ == ST_SQUASH) begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      flagsQ    <= '0;
      blockUp   <= 1'b0;
      unblockUp <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      flagsQ    <= flagsNext;
      blockUp   <= blockNext;
      unblockUp <= unblockNext;
    end
  end

  assign stateOut = stateQ;

  // R3: the two upstream pulses never coincide
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(blockUp && unblockUp));

  // R3: a block pulse accompanies entry to Blocked
  p_block_enter_r3: assert property (@(posedge clk) disable iff (!rstN)
    blockUp |-> stateQ == ST_BLOCKED);

  // R3: never two block pulses back to back
  p_no_double_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    blockUp |=> !blockUp);

  // R7: an unblock pulse leaves the thread running or squashing
  p_unblock_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    unblockUp |-> (stateQ == ST_RUN || stateQ == ST_SQUASH));

  // R8: a flush lands in Squashing
  p_flush_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> stateQ == ST_SQUASH);

endmodule

// File: rtl/skid_stage_dp.sv
module skid_stage_dp
  import skid_stage_pkg::*;
#(
  parameter int FETCH_W = 4,
  parameter int OUT_W   = 2,
  parameter int TAG_W   = 8,
  parameter int DEPTH   = 6,
  localparam int IN_CW  = $clog2(FETCH_W + 1),
  localparam int OUT_CW = $clog2(OUT_W + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_strobe_t               strobe,
  input  logic [IN_CW-1:0]         inCount,
  input  logic [FETCH_W-1:0]       inSquashed,
  input  logic [FETCH_W*TAG_W-1:0] inTag,
  output logic                     leftoverIn,
  output logic                     skidEmptyNext,
  output logic [OUT_W-1:0]         outValid,
  output logic [OUT_CW-1:0]        outCount,
  output logic [OUT_W*TAG_W-1:0]   outTag,
  output logic                     overflowErr
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OSEL_W = (OUT_W > 1) ? $clog2(OUT_W) : 1;

  logic             skidSq  [DEPTH];
  logic [TAG_W-1:0] skidTag [DEPTH];
  logic [CNT_W-1:0] skidCnt;

  logic             padSq  [DEPTH];
  logic [TAG_W-1:0] padTag [DEPTH];
  logic             srcSq  [DEPTH];
  logic [TAG_W-1:0] srcTag [DEPTH];
  logic             nSq    [DEPTH];
  logic [TAG_W-1:0] nTag   [DEPTH];

  logic [OUT_W-1:0] selValid;
  logic [TAG_W-1:0] selTag  [OUT_W];
  logic [TAG_W-1:0] outTagQ [OUT_W];

  int taken, consumed, srcN, baseN, appStart, appN, total;

  // Input slots widened to skid depth so one index range serves both sources.
  for (genvar g = 0; g < DEPTH; g++) begin : g_pad
    if (g < FETCH_W) begin : g_live
      assign padSq[g]  = inSquashed[g];
      assign padTag[g] = inTag[g*TAG_W +: TAG_W];
    end else begin : g_zero
      assign padSq[g]  = 1'b0;
      assign padTag[g] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      srcSq[i]  = strobe.fromSkid ? skidSq[i]  : padSq[i];
      srcTag[i] = strobe.fromSkid ? skidTag[i] : padTag[i];
    end
    srcN = strobe.fromSkid ? int'(skidCnt) : int'(inCount);
  end

  // Oldest-first pick: squashed entries are consumed without taking a slot.
  always_comb begin
    taken    = 0;
    consumed = 0;
    selValid = '0;
    for (int k = 0; k < OUT_W; k++) selTag[k] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < srcN && taken < OUT_W) begin
        consumed = i + 1;
        if (!srcSq[i]) begin
          selValid[OSEL_W'(taken)] = 1'b1;
          selTag[OSEL_W'(taken)]   = srcTag[i];
          taken = taken + 1;
        end
      end
    end
  end

  // Skid update: surviving skid entries first, then the appended input run.
  always_comb begin
    int idx;
    int k;
    if (strobe.clearAll)      baseN = 0;
    else if (strobe.fromSkid) baseN = int'(skidCnt) - consumed;
    else                      baseN = int'(skidCnt);
    appStart = strobe.fromIn ? consumed : 0;
    appN     = (strobe.park || strobe.fromSkid || strobe.fromIn)
               ? int'(inCount) - appStart : 0;
    total    = baseN + appN;
    for (int j = 0; j < DEPTH; j++) begin
      nSq[j]  = 1'b0;
      nTag[j] = '0;
      idx     = strobe.fromSkid ? j + consumed : j;
      k       = appStart + j - baseN;
      if (j < baseN) begin
        nSq[j]  = skidSq[IDX_W'(idx)];
        nTag[j] = skidTag[IDX_W'(idx)];
      end else if (k < int'(inCount)) begin
        nSq[j]  = padSq[IDX_W'(k)];
        nTag[j] = padTag[IDX_W'(k)];
      end
    end
  end

  assign leftoverIn    = strobe.fromIn && (consumed < int'(inCount));
  assign skidEmptyNext = (total == 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skidCnt     <= '0;
      outValid    <= '0;
      outCount    <= '0;
      overflowErr <= 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        skidSq[j]  <= 1'b0;
        skidTag[j] <= '0;
      end
      for (int k = 0; k < OUT_W; k++) outTagQ[k] <= '0;
    end else begin
      skidCnt <= CNT_W'((total > DEPTH) ? DEPTH : total);
      for (int j = 0; j < DEPTH; j++) begin
        skidSq[j]  <= nSq[j];
        skidTag[j] <= nTag[j];
      end
      if (strobe.fromSkid || strobe.fromIn) begin
        outValid <= selValid;
        outCount <= OUT_CW'(taken);
        for (int k = 0; k < OUT_W; k++) outTagQ[k] <= selTag[k];
      end else begin
        outValid <= '0;
        outCount <= '0;
        for (int k = 0; k < OUT_W; k++) outTagQ[k] <= '0;
      end
      if (total > DEPTH) overflowErr <= 1'b1;
    end
  end

  for (genvar g = 0; g < OUT_W; g++) begin : g_out
    assign outTag[g*TAG_W +: TAG_W] = outTagQ[g];
  end

  // R12: held entries never exceed the depth
  p_skid_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    skidCnt <= CNT_W'(DEPTH));

  // R2: a parking cycle forwards nothing
  p_park_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.park |=> outCount == '0);

  // R4: valid bits agree with the count
  p_count_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outValid) == int'(outCount));

  // R11: the overflow flag is sticky
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

endmodule

// File: rtl/skid_stage_ctrl.sv
module skid_stage_ctrl
  import skid_stage_pkg::*;
#(
  parameter int FETCH_W  = 4,
  parameter int OUT_W    = 2,
  parameter int TAG_W    = 8,
  parameter int UP_DELAY = 1,
  parameter int NUM_SRC  = 3,
  localparam int IN_CW   = $clog2(FETCH_W + 1),
  localparam int OUT_CW  = $clog2(OUT_W + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [IN_CW-1:0]         inCount,
  input  logic [FETCH_W-1:0]       inSquashed,
  input  logic [FETCH_W*TAG_W-1:0] inTag,
  input  logic [NUM_SRC-1:0]       stallSet,
  input  logic [NUM_SRC-1:0]       stallClr,
  input  logic                     flushReq,
  input  logic                     flushHold,
  output logic [OUT_W-1:0]         outValid,
  output logic [OUT_CW-1:0]        outCount,
  output logic [OUT_W*TAG_W-1:0]   outTag,
  output logic                     blockUp,
  output logic                     unblockUp,
  output logic [2:0]               stateOut,
  output logic                     overflowErr
);

  // R12: room for everything in flight upstream plus one output's worth
  localparam int DEPTH = UP_DELAY * FETCH_W + OUT_W;

  dp_strobe_t strobe;
  logic       leftoverIn;
  logic       skidEmptyNext;

  skid_stage_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .stallSet      (stallSet),
    .stallClr      (stallClr),
    .flushReq      (flushReq),
    .flushHold     (flushHold),
    .leftoverIn    (leftoverIn),
    .skidEmptyNext (skidEmptyNext),
    .strobe        (strobe),
    .stateOut      (stateOut),
    .blockUp       (blockUp),
    .unblockUp     (unblockUp)
  );

  skid_stage_dp #(
    .FETCH_W (FETCH_W),
    .OUT_W   (OUT_W),
    .TAG_W   (TAG_W),
    .DEPTH   (DEPTH)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .inCount       (inCount),
    .inSquashed    (inSquashed),
    .inTag         (inTag),
    .leftoverIn    (leftoverIn),
    .skidEmptyNext (skidEmptyNext),
    .outValid      (outValid),
    .outCount      (outCount),
    .outTag        (outTag),
    .overflowErr   (overflowErr)
  );

  // R8: a flush forwards nothing in the following cycle
  p_flush_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> outCount == '0);

  // R10: a flush suppresses any block pulse it coincides with
  p_flush_no_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq || flushHold) |=> !blockUp);

endmodule

// File: tb/skid_stage_ctrl_tb.sv
module skid_stage_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FETCH_W  = 4;
  localparam int OUT_W    = 2;
  localparam int TAG_W    = 8;
  localparam int UP_DELAY = 1;
  localparam int NUM_SRC  = 3;
  localparam int DEPTH    = UP_DELAY * FETCH_W + OUT_W;
  localparam int IN_CW    = $clog2(FETCH_W + 1);
  localparam int OUT_CW   = $clog2(OUT_W + 1);

  logic                     clk = 1'b0;
  logic                     rstN;
  logic [IN_CW-1:0]         inCount;
  logic [FETCH_W-1:0]       inSquashed;
  logic [FETCH_W*TAG_W-1:0] inTag;
  logic [NUM_SRC-1:0]       stallSet, stallClr;
  logic                     flushReq, flushHold;
  logic [OUT_W-1:0]         outValid;
  logic [OUT_CW-1:0]        outCount;
  logic [OUT_W*TAG_W-1:0]   outTag;
  logic                     blockUp, unblockUp, overflowErr;
  logic [2:0]               stateOut;

  skid_stage_ctrl #(
    .FETCH_W(FETCH_W), .OUT_W(OUT_W), .TAG_W(TAG_W),
    .UP_DELAY(UP_DELAY), .NUM_SRC(NUM_SRC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inCount(inCount), .inSquashed(inSquashed),
    .inTag(inTag), .stallSet(stallSet), .stallClr(stallClr),
    .flushReq(flushReq), .flushHold(flushHold), .outValid(outValid),
    .outCount(outCount), .outTag(outTag), .blockUp(blockUp),
    .unblockUp(unblockUp), .stateOut(stateOut), .overflowErr(overflowErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit upBlk  = 0;
  int tagSeq = 1;

  // behavioural model state
  int             mState = 0;
  logic [NUM_SRC-1:0] mFlags = '0;
  int             mCnt = 0;
  bit             mSq  [DEPTH];
  int             mTag [DEPTH];
  bit             mErr = 0;
  int             eCnt;
  int             eTag [OUT_W];
  bit             eBlk, eUnb;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void mPush(input bit sq, input int tg);
    if (mCnt < DEPTH) begin
      mSq[mCnt]  = sq;
      mTag[mCnt] = tg;
      mCnt++;
    end else begin
      mErr = 1;
    end
  endfunction

  function automatic int inTagAt(input int k);
    return int'(inTag[k*TAG_W +: TAG_W]);
  endfunction

  task automatic modelStep;
    logic [NUM_SRC-1:0] fn;
    int consumed;
    fn   = (mFlags | stallSet) & ~stallClr;
    eBlk = 0; eUnb = 0; eCnt = 0;
    for (int k = 0; k < OUT_W; k++) eTag[k] = 0;
    if (flushReq || flushHold) begin
      eUnb   = (mState == 2 || mState == 3);
      mCnt   = 0;
      mState = 4;
    end else if (|fn) begin
      for (int k = 0; k < int'(inCount); k++) mPush(inSquashed[k], inTagAt(k));
      if (mState != 2) begin eBlk = 1; mState = 2; end
    end else if (mState == 2 || mState == 3) begin
      consumed = 0;
      for (int i = 0; i < mCnt; i++)
        if (eCnt < OUT_W) begin
          consumed = i + 1;
          if (!mSq[i]) begin eTag[eCnt] = mTag[i]; eCnt++; end
        end
      for (int j = 0; j + consumed < mCnt; j++) begin
        mSq[j]  = mSq[j+consumed];
        mTag[j] = mTag[j+consumed];
      end
      mCnt -= consumed;
      for (int k = 0; k < int'(inCount); k++) mPush(inSquashed[k], inTagAt(k));
      if (mCnt == 0) begin eUnb = 1; mState = 1; end
      else mState = 3;
    end else begin
      consumed = 0;
      for (int i = 0; i < int'(inCount); i++)
        if (eCnt < OUT_W) begin
          consumed = i + 1;
          if (!inSquashed[i]) begin eTag[eCnt] = inTagAt(i); eCnt++; end
        end
      for (int k = consumed; k < int'(inCount); k++) mPush(inSquashed[k], inTagAt(k));
      if (consumed < int'(inCount)) begin eBlk = 1; mState = 2; end
      else if (mState == 4) mState = 1;
    end
    mFlags = fn;
  endtask

  task automatic idleInputs;
    inCount = '0; inSquashed = '0; inTag = '0;
    stallSet = '0; stallClr = '0; flushReq = 0; flushHold = 0;
  endtask

  // One clock: model step, edge, compare every output, clear pulses.
  task automatic cycle(input string req);
    modelStep();
    @(posedge clk);
    #1;
    check(int'(stateOut) == mState, req, "state", int'(stateOut), mState);
    check(blockUp == eBlk, "R3", {req, " blockUp"}, int'(blockUp), int'(eBlk));
    check(unblockUp == eUnb, "R7", {req, " unblockUp"}, int'(unblockUp), int'(eUnb));
    check(int'(outCount) == eCnt, req, "outCount", int'(outCount), eCnt);
    check(int'(outValid) == ((1 << eCnt) - 1), req, "outValid",
          int'(outValid), (1 << eCnt) - 1);
    for (int k = 0; k < OUT_W; k++)
      if (k < eCnt)
        check(int'(outTag[k*TAG_W +: TAG_W]) == eTag[k], req, "outTag",
              int'(outTag[k*TAG_W +: TAG_W]), eTag[k]);
    check(overflowErr == mErr, "R11", {req, " overflowErr"},
          int'(overflowErr), int'(mErr));
    if (blockUp)   upBlk = 1;
    if (unblockUp) upBlk = 0;
    idleInputs();
  endtask

  task automatic offer(input int n, input logic [FETCH_W-1:0] sq);
    inCount    = IN_CW'(n);
    inSquashed = sq;
    for (int k = 0; k < FETCH_W; k++) begin
      inTag[k*TAG_W +: TAG_W] = TAG_W'(tagSeq);
      tagSeq = (tagSeq % 250) + 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    check(stateOut == 3'd0, "R1", "state", int'(stateOut), 0);
    check(!blockUp && !unblockUp, "R1", "pulses", int'({blockUp, unblockUp}), 0);
    check(outCount == '0, "R1", "outCount", int'(outCount), 0);
    check(!overflowErr, "R1", "overflowErr", int'(overflowErr), 0);

    // R4: three entries, middle one squashed -> two forwarded, stays Idle
    offer(3, 4'b0010); cycle("R4");
    // R5: four live entries -> two out, two parked, block pulse
    offer(4, 4'b0000); cycle("R5");
    // R6/R7: stall gone -> drain skid, unblock, Running
    cycle("R6"); cycle("R7");

    // R2: two sources stall, lifted one at a time
    stallSet = 3'b010; offer(2, 4'b0000); cycle("R2");
    stallSet = 3'b101; stallClr = 3'b010; offer(1, 4'b0000); cycle("R2");
    stallClr = 3'b001; cycle("R2");
    stallClr = 3'b100; offer(3, 4'b0001); cycle("R6");
    cycle("R6"); cycle("R7"); cycle("R7");

    // R8: flush while Blocked, then hold, then R9 recovery
    stallSet = 3'b001; offer(3, 4'b0000); cycle("R2");
    flushReq = 1; stallClr = 3'b001; cycle("R8");
    flushHold = 1; offer(2, 4'b0000); cycle("R8");
    offer(3, 4'b0100); cycle("R9");

    // R10: stall set together with flush from Running
    cycle("R9");
    flushReq = 1; stallSet = 3'b100; offer(4, 4'b0000); cycle("R10");
    stallClr = 3'b100; cycle("R10");
    cycle("R9");

    // random mixed traffic with a well-behaved upstream
    for (int n = 0; n < 4000; n++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if ($urandom_range(0, 15) == 0) stallSet[s] = 1'b1;
        if ($urandom_range(0, 5) == 0)  stallClr[s] = 1'b1;
      end
      flushReq  = ($urandom_range(0, 39) == 0);
      flushHold = ($urandom_range(0, 59) == 0);
      if (!upBlk) offer($urandom_range(0, FETCH_W), FETCH_W'($urandom() & $urandom()));
      cycle("R4");
    end

    // R12 and R11: fill skid to its depth, then one past it
    flushReq = 1; stallClr = '1; cycle("R8");
    cycle("R9");
    stallSet = 3'b001; offer(4, 4'b0000); cycle("R12");
    offer(2, 4'b0000); cycle("R12");
    check(!overflowErr, "R12", "full skid overflowErr", int'(overflowErr), 0);
    offer(1, 4'b0000); cycle("R11");
    check(overflowErr, "R11", "overflowErr after excess", int'(overflowErr), 1);
    flushReq = 1; stallClr = 3'b001; cycle("R11");
    check(overflowErr, "R11", "sticky after flush", int'(overflowErr), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule